// File: doc/BRIEF.md
# Programmable Conversion Period Timer

This block sets the conversion rate of a data converter interface. A transmit path and a receive path each run a two-stage divider. An A counter divides the master clock. A B counter counts completed A segments. When both counters finish, the path emits a one-cycle conversion strobe. The conversion period in master-clock cycles is therefore A times B.

The host writes new A and B counts for both paths in a single write cycle. The block screens the values before it loads them. B counts that are too small are replaced by a fixed safe value. Degenerate A counts either shut the timer down or raise a serial-port halt flag, and both flags stay set until reset.

The host can also request a one-shot period trim. The request is accepted only in the cycle in which the transmit strobe is high. It lengthens or shortens the final A segment of one transmit period and of one receive period, and then the base count applies again. A gap monitor flags strobes that arrive closer together than a minimum interval. A link-loss input freezes both dividers.

Top module: `cpt_timer`

## Requirements
- R1: After reset, all strobes and flags are low and both paths run with A=DEF_A and B=DEF_B. The first strobe of each path is high in the cycle after the DEF_A*DEF_B-th rising edge following the release of reset.
- R2: In steady state each path strobes every A*B cycles, for one cycle only. The transmit and receive paths use their own counts independently.
- R3: A written B count below 15 is replaced by 18 (period A*18). A B count of 15 or more is used unchanged.
- R4: A trim request (adj_req) is taken only on an edge where tx_conv is high. It makes exactly one transmit period A*(B-1)+E long, where E is given by R5, and the following periods return to A*B. A request while tx_conv is low has no effect.
- R5: E is (A+T) mod 64 when adj_sub=0, or (A-T) mod 64 when adj_sub=1. T is adj_trim read as 6-bit two's complement. A negative result therefore wraps up by 64. When the folded value is 0 or 1, E is the plain A count.
- R6: On the receive path the trim goes into the first receive period whose final A segment begins after the accepting edge. If that segment has already begun in the current period, the trim goes into the next period. It is applied once.
- R7: A write whose transmit or receive A count is 0 or 1 sets shutdown and leaves the registers and counters unchanged. While shut down, no strobes appear and later writes are ignored. Only reset clears shutdown.
- R8: A write whose transmit or receive A count is below 4 (word_mode=1) or below 5 (word_mode=0) sets port_halt. The strobes continue, and port_halt stays set until reset.
- R9: A strobe that comes fewer than MIN_GAP cycles after the previous strobe of the same path sets that path's bit in viol (bit 0 transmit, bit 1 receive). The bit stays set until viol_clr, and a new violation takes precedence over a clear.
- R10: While link_ok is low, both dividers hold their state and no strobes are issued. Each low cycle lengthens the running period by one cycle.
- R11: An accepted write restarts both paths from the new counts. The first strobe comes A*B cycles after the write edge, and any pending trim is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_ok | input | 1 | Host link present; low freezes the dividers |
| word_mode | input | 1 | 1 = word serial mode (minimum A 4), 0 = byte mode (minimum A 5) |
| cfg_wr | input | 1 | Write strobe for the four count fields |
| cfg_ta | input | AW | Transmit A count |
| cfg_tb | input | BW | Transmit B count |
| cfg_ra | input | AW | Receive A count |
| cfg_rb | input | BW | Receive B count |
| adj_req | input | 1 | One-shot period trim request |
| adj_sub | input | 1 | 1 = subtract the trim, 0 = add it |
| adj_trim | input | AW | Signed trim value |
| viol_clr | input | 1 | Clears the interval violation flags |
| tx_conv | output | 1 | Transmit conversion strobe |
| rx_conv | output | 1 | Receive conversion strobe |
| shutdown | output | 1 | Sticky shutdown flag |
| port_halt | output | 1 | Sticky serial-port halt flag |
| viol | output | 2 | Sticky interval violation flags, bit 0 transmit, bit 1 receive |

## Verification
Some properties are checked on every cycle. Strobes never appear on consecutive cycles and never while the dividers are frozen or shut down. Both fault flags are sticky. Stored B counts never fall below the legal floor, and the A counter never reaches zero. A violation bit is kept unless it is cleared.

Other behaviour needs the bench's scenarios. These include the exact period lengths, the folding of every trim value in both directions, and which receive period takes a trim. They also include the interval threshold at exactly MIN_GAP against one segment less, and the mode-dependent halt limits.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
   typedef enum int {PATH_TX = 0, PATH_RX = 1} path_e;
   localparam int NPATH      = 2;
   localparam int A_SHUT_LIM = 2;
   localparam int A_WORD_LIM = 4;
   localparam int A_BYTE_LIM = 5;
endpackage

// File: rtl/cpt_trim.sv
module cpt_trim #(
   parameter int AW = 6
) (
   input  logic [AW-1:0] base_a_i,
   input  logic [AW-1:0] trim_i,
   input  logic          sub_i,
   output logic [AW-1:0] eff_o
);
   localparam int XW = AW + 2;
   logic [XW-1:0] base_x, trim_x, raw_x;

   always_comb begin
      base_x = {2'b00, base_a_i};
      trim_x = {{2{trim_i[AW-1]}}, trim_i};
      raw_x  = sub_i ? (base_x - trim_x) : (base_x + trim_x);
      // folding keeps the low AW bits; degenerate results fall back to base
      eff_o  = (raw_x[AW-1:0] < AW'(cpt_pkg::A_SHUT_LIM)) ? base_a_i : raw_x[AW-1:0];
   end
endmodule

// File: rtl/cpt_path.sv
module cpt_path #(
   parameter int AW    = 6,
   parameter int BW    = 8,
   parameter int DEF_A = 10,
   parameter int DEF_B = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic          load_i,
   input  logic [AW-1:0] ld_a_i,
   input  logic [BW-1:0] ld_b_i,
   input  logic [AW-1:0] base_a_i,
   input  logic [BW-1:0] base_b_i,
   input  logic [AW-1:0] eff_a_i,
   input  logic          pend_set_i,
   output logic          conv_o
);
   logic [AW-1:0] a_cnt;
   logic [BW-1:0] b_cnt;
   logic          pend;
   logic          a_end, b_end, b_last;

   assign a_end  = (a_cnt == AW'(1));
   assign b_end  = (b_cnt == BW'(1));
   assign b_last = (b_cnt == BW'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt  <= AW'(DEF_A);
         b_cnt  <= BW'(DEF_B);
         pend   <= 1'b0;
         conv_o <= 1'b0;
      end else begin
         conv_o <= 1'b0;
         if (load_i) begin
            a_cnt <= ld_a_i;
            b_cnt <= ld_b_i;
            pend  <= 1'b0;
         end else if (run_i) begin
            if (!a_end) begin
               a_cnt <= a_cnt - AW'(1);
            end else if (b_end) begin
               conv_o <= 1'b1;
               a_cnt  <= base_a_i;
               b_cnt  <= base_b_i;
            end else begin
               b_cnt <= b_cnt - BW'(1);
               if (b_last && pend) begin
                  a_cnt <= eff_a_i;
                  pend  <= 1'b0;
               end else begin
                  a_cnt <= base_a_i;
               end
            end
         end
         if (pend_set_i) pend <= 1'b1;
      end
   end

   // R2
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_o |=> !conv_o);
   // R10
   strobe_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_o |-> $past(run_i));
   // R5
   a_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_cnt != '0);
   // R10
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> ($stable(a_cnt) && $stable(b_cnt)));
endmodule

// File: rtl/cpt_gapmon.sv
module cpt_gapmon #(
   parameter int MIN_GAP = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_i,
   input  logic clr_i,
   output logic viol_o
);
   localparam int GW = $clog2(MIN_GAP + 1);
   logic [GW-1:0] gap;
   logic          seen, hit;

   assign hit = conv_i && seen && (gap < GW'(MIN_GAP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap    <= '0;
         seen   <= 1'b0;
         viol_o <= 1'b0;
      end else begin
         viol_o <= (viol_o && !clr_i) || hit;
         if (conv_i) begin
            gap  <= GW'(1);
            seen <= 1'b1;
         end else if (gap < GW'(MIN_GAP)) begin
            gap <= gap + GW'(1);
         end
      end
   end

   // R9
   viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_o && !clr_i) |=> viol_o);
   // R9
   viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(viol_o) |-> $past(conv_i));
endmodule

// File: rtl/cpt_timer.sv
module cpt_timer #(
   parameter int AW      = 6,
   parameter int BW      = 8,
   parameter int B_MIN   = 15,
   parameter int B_FIX   = 18,
   parameter int DEF_A   = 10,
   parameter int DEF_B   = 18,
   parameter int MIN_GAP = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_ok,
   input  logic          word_mode,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_ta,
   input  logic [BW-1:0] cfg_tb,
   input  logic [AW-1:0] cfg_ra,
   input  logic [BW-1:0] cfg_rb,
   input  logic          adj_req,
   input  logic          adj_sub,
   input  logic [AW-1:0] adj_trim,
   input  logic          viol_clr,
   output logic          tx_conv,
   output logic          rx_conv,
   output logic          shutdown,
   output logic          port_halt,
   output logic [1:0]    viol
);
   import cpt_pkg::*;

   if (AW < 3)                  $error("AW too small for the A limits");
   if (DEF_A < A_BYTE_LIM)      $error("DEF_A must be legal in both modes");
   if (DEF_A >= (1 << AW))      $error("DEF_A does not fit AW");
   if (B_FIX < B_MIN)           $error("B_FIX must not be below B_MIN");
   if (DEF_B < B_MIN)           $error("DEF_B must not be below B_MIN");
   if (B_FIX >= (1 << BW))      $error("B_FIX does not fit BW");
   if (MIN_GAP < 2)             $error("MIN_GAP must be at least 2");

   logic [NPATH-1:0][AW-1:0] a_in, a_q, eff_a;
   logic [NPATH-1:0][BW-1:0] b_in, b_fix, b_q;
   logic [NPATH-1:0]         conv;
   logic [AW-1:0]            a_lim, trim_q;
   logic                     sub_q, shut_q, halt_q;
   logic                     shut_cond, halt_cond, accept, run, adj_take;

   assign a_in  = {cfg_ra, cfg_ta};
   assign b_in  = {cfg_rb, cfg_tb};
   assign a_lim = word_mode ? AW'(A_WORD_LIM) : AW'(A_BYTE_LIM);

   assign shut_cond = (cfg_ta < AW'(A_SHUT_LIM)) || (cfg_ra < AW'(A_SHUT_LIM));
   assign halt_cond = (cfg_ta < a_lim) || (cfg_ra < a_lim);
   assign accept    = cfg_wr && !shut_q && !shut_cond;
   assign run       = link_ok && !shut_q;
   assign adj_take  = adj_req && conv[PATH_TX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= {NPATH{AW'(DEF_A)}};
         b_q    <= {NPATH{BW'(DEF_B)}};
         shut_q <= 1'b0;
         halt_q <= 1'b0;
         trim_q <= '0;
         sub_q  <= 1'b0;
      end else begin
         if (cfg_wr && !shut_q) begin
            if (shut_cond) shut_q <= 1'b1;
            if (halt_cond) halt_q <= 1'b1;
         end
         if (accept) begin
            a_q <= a_in;
            b_q <= b_fix;
         end
         if (adj_take) begin
            trim_q <= adj_trim;
            sub_q  <= adj_sub;
         end
      end
   end

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      assign b_fix[p] = (b_in[p] < BW'(B_MIN)) ? BW'(B_FIX) : b_in[p];

      cpt_trim #(.AW(AW)) trim_i (
         .base_a_i (a_q[p]),
         .trim_i   (trim_q),
         .sub_i    (sub_q),
         .eff_o    (eff_a[p])
      );

      cpt_path #(.AW(AW), .BW(BW), .DEF_A(DEF_A), .DEF_B(DEF_B)) path_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .run_i      (run),
         .load_i     (accept),
         .ld_a_i     (a_in[p]),
         .ld_b_i     (b_fix[p]),
         .base_a_i   (a_q[p]),
         .base_b_i   (b_q[p]),
         .eff_a_i    (eff_a[p]),
         .pend_set_i (adj_take),
         .conv_o     (conv[p])
      );

      cpt_gapmon #(.MIN_GAP(MIN_GAP)) gap_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .conv_i (conv[p]),
         .clr_i  (viol_clr),
         .viol_o (viol[p])
      );

      // R3
      b_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         b_q[p] >= BW'(B_MIN));
      // R7
      a_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         a_q[p] >= AW'(A_SHUT_LIM));
   end

   assign tx_conv   = conv[PATH_TX];
   assign rx_conv   = conv[PATH_RX];
   assign shutdown  = shut_q;
   assign port_halt = halt_q;

   // R7
   shut_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shut_q |=> shut_q);
   // R7
   shut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(shut_q) |-> (!tx_conv && !rx_conv));
   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> halt_q);
   // R7
   shut_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shut_q |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/cpt_timer_tb.sv
`timescale 1ns/1ps
module cpt_timer_tb_top;
   localparam int WD = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic link_ok = 1'b1, word_mode = 1'b1, cfg_wr = 1'b0;
   logic [5:0] cfg_ta = 6'd10, cfg_ra = 6'd10, adj_trim = '0;
   logic [7:0] cfg_tb = 8'd15, cfg_rb = 8'd15;
   logic adj_req = 1'b0, adj_sub = 1'b0, viol_clr = 1'b0;
   logic tx_conv, rx_conv, shutdown, port_halt;
   logic [1:0] viol;

   int cyc = 0, nchk = 0, nfail = 0;
   bit done = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cpt_timer dut_i (
      .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .word_mode(word_mode),
      .cfg_wr(cfg_wr), .cfg_ta(cfg_ta), .cfg_tb(cfg_tb), .cfg_ra(cfg_ra),
      .cfg_rb(cfg_rb), .adj_req(adj_req), .adj_sub(adj_sub),
      .adj_trim(adj_trim), .viol_clr(viol_clr), .tx_conv(tx_conv),
      .rx_conv(rx_conv), .shutdown(shutdown), .port_halt(port_halt),
      .viol(viol));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic do_reset(output int r);
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; r = cyc;
   endtask

   task automatic do_write(input int ta, input int tb, input int ra, input int rb, output int w);
      @(negedge clk);
      cfg_ta = 6'(ta); cfg_tb = 8'(tb); cfg_ra = 6'(ra); cfg_rb = 8'(rb);
      cfg_wr = 1'b1;
      @(negedge clk); cfg_wr = 1'b0; w = cyc;
   endtask

   task automatic wait_tx(output int t);
      do @(negedge clk); while (tx_conv !== 1'b1);
      t = cyc;
   endtask

   task automatic wait_rx(output int t);
      do @(negedge clk); while (rx_conv !== 1'b1);
      t = cyc;
   endtask

   task automatic issue_adj(input int tr, input bit sb);
      adj_trim = 6'(tr); adj_sub = sb; adj_req = 1'b1;
      @(negedge clk); adj_req = 1'b0;
   endtask

   function automatic int eff_of(input int a, input int tr, input bit sb);
      int raw;
      raw = sb ? a - tr : a + tr;
      raw = ((raw % 64) + 64) % 64;
      return (raw < 2) ? a : raw;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD);
         summary();
         $finish;
      end
   end

   initial begin
      int r, w, t0, t1, t2, tr0, tr1, tr2;
      // R1 reset state and default period
      do_reset(r);
      chk({tx_conv, rx_conv, shutdown, port_halt, viol} == 6'b0, "R1 reset outputs",
          {tx_conv, rx_conv, shutdown, port_halt, viol}, 0);
      wait_tx(t0);
      chk(t0 - r == 180, "R1 first default strobe", t0 - r, 180);
      chk(rx_conv == 1'b1, "R1 rx default strobe", rx_conv, 1);

      // R2 R11 independent paths, restart on write
      do_write(10, 15, 7, 20, w);
      wait_rx(tr0);
      chk(tr0 - w == 140, "R11 rx first strobe after write", tr0 - w, 140);
      wait_tx(t0);
      chk(t0 - w == 150, "R11 tx first strobe after write", t0 - w, 150);
      @(negedge clk);
      chk(tx_conv == 1'b0, "R2 strobe one cycle", tx_conv, 0);
      wait_rx(tr1);
      chk(tr1 - tr0 == 140, "R2 rx period", tr1 - tr0, 140);
      wait_tx(t1);
      chk(t1 - t0 == 150, "R2 tx period", t1 - t0, 150);

      // R3 B floor replacement
      do_write(10, 14, 10, 3, w);
      wait_tx(t0);
      chk(t0 - w == 180, "R3 tx B=14 replaced", t0 - w, 180);
      chk(rx_conv == 1'b1, "R3 rx B=3 replaced", rx_conv, 1);
      do_write(10, 15, 10, 15, w);
      wait_tx(t0);
      chk(t0 - w == 150, "R3 B=15 kept", t0 - w, 150);

      // R4 R5 sweep of every trim value in both directions
      for (int sb = 0; sb < 2; sb++) begin
         for (int tr = -32; tr < 32; tr++) begin
            int e;
            e = eff_of(10, tr, sb[0]);
            wait_tx(t0);
            issue_adj(tr, sb[0]);
            wait_tx(t1);
            chk(t1 - t0 == 140 + e, "R5 trimmed tx period", t1 - t0, 140 + e);
            chk(rx_conv == 1'b1, "R5 rx trimmed alongside", rx_conv, 1);
            wait_tx(t2);
            chk(t2 - t1 == 150, "R4 one-shot revert", t2 - t1, 150);
         end
      end

      // R4 request outside the strobe is ignored
      wait_tx(t0);
      @(negedge clk);
      adj_trim = 6'd20; adj_sub = 1'b0; adj_req = 1'b1;
      repeat (5) @(negedge clk);
      adj_req = 1'b0;
      wait_tx(t1);
      chk(t1 - t0 == 150, "R4 request off-strobe ignored", t1 - t0, 150);

      // R6 receive final segment already begun: trim goes to the next period
      do_write(10, 15, 10, 16, w);
      wait_tx(t0);
      issue_adj(3, 1'b0);
      wait_rx(tr0);
      chk(tr0 - w == 160, "R6 rx current period untouched", tr0 - w, 160);
      wait_rx(tr1);
      chk(tr1 - w == 323, "R6 rx next period trimmed", tr1 - w, 323);
      wait_rx(tr2);
      chk(tr2 - tr1 == 160, "R6 rx trim once", tr2 - tr1, 160);
      // R6 final segment not yet begun: trim in the current period
      do_write(10, 15, 10, 16, w);
      wait_tx(t0);
      wait_tx(t0);
      chk(t0 - w == 300, "R6 second tx strobe", t0 - w, 300);
      issue_adj(3, 1'b0);
      wait_rx(tr0);
      chk(tr0 - w == 323, "R6 rx current period trimmed", tr0 - w, 323);

      // R10 link loss freezes the dividers
      do_write(10, 15, 10, 15, w);
      wait_tx(t0);
      repeat (5) @(negedge clk);
      link_ok = 1'b0;
      for (int i = 0; i < 37; i++) begin
         @(negedge clk);
         chk(tx_conv == 1'b0 && rx_conv == 1'b0, "R10 no strobe on link loss", tx_conv, 0);
      end
      link_ok = 1'b1;
      wait_tx(t1);
      chk(t1 - t0 == 187, "R10 period stretched", t1 - t0, 187);

      // R9 interval threshold, R8 word-mode limit
      do_write(4, 16, 4, 16, w);
      @(negedge clk); viol_clr = 1'b1; @(negedge clk); viol_clr = 1'b0;
      repeat (3) wait_tx(t0);
      @(negedge clk);
      chk(viol == 2'b00, "R9 gap equal to MIN_GAP ok", viol, 0);
      chk(port_halt == 1'b0, "R8 word mode A=4 legal", port_halt, 0);
      do_write(4, 15, 4, 15, w);
      repeat (3) wait_tx(t0);
      @(negedge clk);
      chk(viol == 2'b11, "R9 short gap flagged", viol, 3);
      repeat (10) @(negedge clk);
      chk(viol == 2'b11, "R9 flag sticky", viol, 3);
      viol_clr = 1'b1; @(negedge clk); viol_clr = 1'b0;
      chk(viol == 2'b00, "R9 flag cleared", viol, 0);
      wait_tx(t0);
      @(negedge clk);
      chk(viol == 2'b11, "R9 flag sets again", viol, 3);

      // R8 byte-mode limit
      word_mode = 1'b0;
      do_write(5, 15, 5, 15, w);
      @(negedge clk);
      chk(port_halt == 1'b0, "R8 byte mode A=5 legal", port_halt, 0);
      do_write(10, 15, 4, 15, w);
      @(negedge clk);
      chk(port_halt == 1'b1, "R8 byte mode A=4 halts", port_halt, 1);
      wait_tx(t0);
      chk(t0 - w == 150, "R8 strobes continue", t0 - w, 150);
      do_write(10, 15, 10, 15, w);
      @(negedge clk);
      chk(port_halt == 1'b1, "R8 halt sticky", port_halt, 1);
      word_mode = 1'b1;

      // R7 shutdown
      do_write(10, 15, 1, 15, w);
      @(negedge clk);
      chk(shutdown == 1'b1, "R7 shutdown set", shutdown, 1);
      do_write(10, 15, 10, 15, w);
      begin
         int seen;
         seen = 0;
         for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (tx_conv || rx_conv) seen++;
         end
         chk(seen == 0, "R7 no strobes while shut", seen, 0);
      end
      chk(shutdown == 1'b1, "R7 write ignored while shut", shutdown, 1);
      do_reset(r);
      chk(shutdown == 1'b0 && port_halt == 1'b0, "R7 reset clears flags",
          {shutdown, port_halt}, 0);
      wait_tx(t0);
      chk(t0 - r == 180, "R1 default after reset", t0 - r, 180);

      done = 1;
      summary();
      $finish;
   end
endmodule